// File: doc/BRIEF.md
# Log-Domain Discrete Sampler

This block draws one index from K candidates. Each candidate carries a signed fixed-point energy, and the chance of drawing a candidate grows with the exponential of its energy. A draw runs in three passes over the candidates, one candidate per cycle. The first pass finds the largest energy. The second pass turns each candidate's distance below that maximum into a weight, using a constant table of decaying exponentials, and keeps a running cumulative sum. The third pass compares each cumulative value with a uniform random fraction of the total and picks the first candidate whose cumulative value lies above it.

The random fraction comes from an internal linear-feedback shift register. Software may reseed it, and it advances once per accepted draw. The block is meant to sit in the update loop of a Gibbs-style sampler: a neighbour supplies the energies of one variable's possible values, pulses start, and reads the chosen value when done pulses.

Top module: `lds_sampler`

## Requirements
- R1: After reset, done_o and busy_o are 0 and index_o is 0.
- R2: If every candidate except one lies at least DEPTH LSBs below the maximum energy, the draw returns that candidate for any random value.
- R3: Energies are two's-complement EW-bit numbers with FRAC fraction bits. A candidate at the maximum gets weight 2^WW-1. U is the low UW bits of the generator state at the accepted start. The result is the smallest i whose cumulative weight (sum of weights 0..i) is greater than floor(U*total/2^UW).
- R4: Adding the same offset to all energies does not change the drawn index, provided the offset keeps every energy in range.
- R5: A candidate d LSBs below the maximum gets weight round((2^WW-1)*exp(-d/2^FRAC)) for d < DEPTH, and weight 0 for d >= DEPTH. Over all 2^UW values of U, the fraction of draws returning a candidate therefore matches its exponential share to within 3/2^UW.
- R6: busy_o rises in the cycle after an accepted start. done_o rises exactly 2K+2+index_o clock edges after the start edge, and busy_o falls at that same edge.
- R7: done_o is high for exactly one cycle per draw. index_o changes only at the edge that raises done_o and holds its value until the next draw completes.
- R8: The energies are captured at the accepted start. A start or a change of energies while busy_o is high has no effect on the draw in progress and does not start another one.
- R9: seed_load_i writes seed_i into the generator, with a seed of 0 replaced by 1. The generator steps once per accepted draw, so repeated draws without reseeding give different indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a draw; accepted only when idle |
| energy_i | input | K*EW | Packed signed energies; candidate k is in bits [k*EW +: EW] |
| seed_load_i | input | 1 | Load seed_i into the random generator |
| seed_i | input | LW | Generator seed |
| busy_o | output | 1 | Draw in progress |
| done_o | output | 1 | One-cycle pulse when index_o is new |
| index_o | output | log2(K) | Drawn candidate index |

## Verification
The hardest case to reach from the ports is a known random value at the moment of a draw. Without one, the exact selection rule and the exponential weight shares could only be checked statistically. The bench reseeds before every draw, so U equals the seed's low bits. It then sweeps every U against tied-maximum patterns, where all weights are exactly 2^WW-1 and the expected index is pure arithmetic. It also sweeps every U against two-candidate pairs at chosen distances, comparing the share of draws with an exponential computed in real arithmetic.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAX,
    ST_SUM,
    ST_THR,
    ST_SCAN
  } lds_state_e;

  localparam int unsigned QB = 24;

  // exp(-2^-frac) in Q24 via alternating series
  function automatic longint unsigned exp_step_q(int unsigned frac);
    longint unsigned t;
    longint          s;
    t = longint'(1) << QB;
    s = longint'(1) << QB;
    for (int k = 1; k <= 12; k++) begin
      t = (t >> frac) / longint'(k);
      if (k % 2 == 1) s = s - longint'(t);
      else            s = s + longint'(t);
    end
    return longint'(s);
  endfunction

  // round(wmax * exp(-d / 2^frac))
  function automatic int unsigned exp_weight(int unsigned d, int unsigned frac,
                                             int unsigned wmax);
    longint unsigned r;
    longint unsigned w;
    r = exp_step_q(frac);
    w = longint'(wmax) << QB;
    for (int unsigned j = 0; j < d; j++) w = (w * r) >> QB;
    return int'((w + (longint'(1) << (QB - 1))) >> QB);
  endfunction

endpackage

// File: rtl/lds_prng.sv
module lds_prng #(
  parameter int unsigned        LW   = 16,
  parameter int unsigned        UW   = 8,
  parameter logic [LW-1:0]      TAPS = 16'hB400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] seed_i,
  input  logic          step_i,
  output logic [UW-1:0] u_o
);

  logic [LW-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LW'(1);
    end else if (load_i) begin
      st_q <= (seed_i == '0) ? LW'(1) : seed_i;
    end else if (step_i) begin
      st_q <= (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
    end
  end

  assign u_o = st_q[UW-1:0];

endmodule

// File: rtl/lds_exp_lut.sv
module lds_exp_lut #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned FRAC  = 3,
  parameter int unsigned WW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  input  logic          hit_i,
  output logic [WW-1:0] w_o
);

  logic [WW-1:0] tbl [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_tbl
    localparam int unsigned WV = lds_pkg::exp_weight(j, FRAC, (1 << WW) - 1);
    assign tbl[j] = WW'(WV);
  end

  assign w_o = hit_i ? tbl[addr_i] : '0;

endmodule

// File: rtl/lds_cum_bank.sv
module lds_cum_bank #(
  parameter int unsigned K  = 8,
  parameter int unsigned CW = 11,
  localparam int unsigned IW = $clog2(K)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o
);

  logic [CW-1:0] mem_q [K];

  for (genvar k = 0; k < K; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[k] <= '0;
      else if (we_i && waddr_i == IW'(k))    mem_q[k] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/lds_sampler.sv
module lds_sampler #(
  parameter int unsigned K     = 8,
  parameter int unsigned EW    = 8,
  parameter int unsigned FRAC  = 3,
  parameter int unsigned WW    = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 16,
  parameter int unsigned UW    = 8,
  localparam int unsigned IW   = $clog2(K),
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = WW + IW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [K*EW-1:0] energy_i,
  input  logic            seed_load_i,
  input  logic [LW-1:0]   seed_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [IW-1:0]   index_o
);
  import lds_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(K - 1);

  lds_state_e           state_q;
  logic [IW-1:0]        i_q;
  logic signed [EW-1:0] e_q [K];
  logic signed [EW-1:0] e_in [K];
  logic signed [EW-1:0] max_q;
  logic [CW-1:0]        acc_q;
  logic [CW-1:0]        thr_q;
  logic [UW-1:0]        u_q;
  logic [UW-1:0]        u_rng;
  logic [IW-1:0]        index_q;
  logic                 done_q;
  logic                 accept;

  for (genvar k = 0; k < K; k++) begin : g_unpack
    assign e_in[k] = energy_i[k*EW +: EW];
  end

  assign accept = start_i && (state_q == ST_IDLE);

  lds_prng #(.LW(LW), .UW(UW)) u_prng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed_load_i),
    .seed_i (seed_i),
    .step_i (accept),
    .u_o    (u_rng)
  );

  // distance of current candidate below the maximum
  logic signed [EW-1:0] e_cur;
  logic signed [EW:0]   diff_s;
  logic [EW:0]          diff_u;
  logic                 in_rng;
  logic [WW-1:0]        w_cur;
  logic [CW-1:0]        acc_nx;

  assign e_cur  = e_q[i_q];
  assign diff_s = {max_q[EW-1], max_q} - {e_cur[EW-1], e_cur};
  assign diff_u = diff_s;
  assign in_rng = 32'(diff_u) < 32'(DEPTH);
  assign acc_nx = acc_q + CW'(w_cur);

  lds_exp_lut #(.DEPTH(DEPTH), .FRAC(FRAC), .WW(WW)) u_lut (
    .addr_i (diff_u[AW-1:0]),
    .hit_i  (in_rng),
    .w_o    (w_cur)
  );

  logic [CW-1:0] cum_rd;

  lds_cum_bank #(.K(K), .CW(CW)) u_cum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (state_q == ST_SUM),
    .waddr_i (i_q),
    .wdata_i (acc_nx),
    .raddr_i (i_q),
    .rdata_o (cum_rd)
  );

  logic [UW+CW-1:0] prod;
  assign prod = {{CW{1'b0}}, u_q} * {{UW{1'b0}}, acc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      max_q   <= '0;
      acc_q   <= '0;
      thr_q   <= '0;
      u_q     <= '0;
      index_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            u_q     <= u_rng;
            max_q   <= {1'b1, {(EW-1){1'b0}}};
            i_q     <= '0;
            state_q <= ST_MAX;
          end
        end
        ST_MAX: begin
          if (e_cur > max_q) max_q <= e_cur;
          if (i_q == LAST) begin
            i_q     <= '0;
            acc_q   <= '0;
            state_q <= ST_SUM;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        ST_SUM: begin
          acc_q <= acc_nx;
          if (i_q == LAST) begin
            i_q     <= '0;
            state_q <= ST_THR;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        ST_THR: begin
          thr_q   <= prod[UW+CW-1:UW];
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (cum_rd > thr_q || i_q == LAST) begin
            index_q <= i_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            i_q <= i_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < K; k++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     e_q[k] <= '0;
      else if (accept) e_q[k] <= e_in[k];
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign index_o = index_q;

endmodule

// File: rtl/lds_sampler_chk.sv
module lds_sampler_chk #(
  parameter int unsigned K  = 8,
  localparam int unsigned IW = $clog2(K)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [IW-1:0] index_o
);

  int unsigned cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cyc_q <= 0;
    else if (start_i && !busy_o)  cyc_q <= 0;
    else if (busy_o)              cyc_q <= cyc_q + 1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                            // R7
  AST_INDEX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(index_o));                                  // R7
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);                               // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) && !busy_o));                  // R6
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cyc_q == 2*K + 2 + int'(index_o)));          // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));                              // R8

endmodule

bind lds_sampler lds_sampler_chk #(.K(K)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .index_o (index_o)
);

// File: tb/tb_lds_sampler.sv
`timescale 1ns/1ps
module tb_lds_sampler;
  localparam int K = 8, EW = 8, FRAC = 3, WW = 8, DEPTH = 64, LW = 16, UW = 8;
  localparam int IW = $clog2(K);
  localparam int WMAX = (1 << WW) - 1;

  logic clk = 0, rst_ni = 0, start = 0, seed_load = 0;
  logic [K*EW-1:0] en = '0;
  logic [LW-1:0] seed = '0;
  logic busy, done;
  logic [IW-1:0] idx;

  int checks = 0, fails = 0;
  bit timeout = 0;

  always #2 clk = ~clk;

  lds_sampler #(.K(K), .EW(EW), .FRAC(FRAC), .WW(WW), .DEPTH(DEPTH), .LW(LW), .UW(UW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .energy_i(en),
    .seed_load_i(seed_load), .seed_i(seed), .busy_o(busy), .done_o(done), .index_o(idx));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_e(int k, int v);
    en[k*EW +: EW] = EW'(v);
  endtask

  task automatic fill(int v);
    for (int k = 0; k < K; k++) set_e(k, v);
  endtask

  task automatic load_seed(logic [LW-1:0] s);
    @(negedge clk); seed_load = 1; seed = s;
    @(negedge clk); seed_load = 0;
  endtask

  task automatic draw(output int r, output int lat);
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    lat = 0;
    while (1) begin
      @(posedge clk); lat++;
      #1;
      if (done) break;
      if (lat > 1000) begin timeout = 1; break; end
    end
    r = int'(idx);
  endtask

  // ties: mask bits tied at base, the rest far below
  task automatic tie_sweep(logic [K-1:0] mask, int base, int low, string req);
    int n, r, lat, thr, kk, expi, cnt;
    n = $countones(mask);
    for (int k = 0; k < K; k++) set_e(k, mask[k] ? base : low);
    for (int u = 0; u < (1 << UW); u++) begin
      load_seed({8'hA5, 8'(u)});
      draw(r, lat);
      thr = (u * n * WMAX) >> UW;
      kk = thr / WMAX;
      expi = -1; cnt = 0;
      for (int k = 0; k < K; k++)
        if (mask[k]) begin
          if (cnt == kk && expi < 0) expi = k;
          cnt++;
        end
      chk(req, r, expi);
      chk("R6 latency", lat, 2*K + 2 + r);
    end
  endtask

  initial begin
    int r, lat, c, lo, hi;
    real w, e;
    int seen [K];
    bit moved;
    #7; rst_ni = 1;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 index", int'(idx), 0);

    // R2: sole nonzero weight
    for (int p = 0; p < K; p++) begin
      for (int u = 0; u < 256; u += 37) begin
        fill(-10); set_e(p, 60);
        load_seed({8'h3C, 8'(u)});
        draw(r, lat); chk("R2 sole high", r, p);
        fill(-128); set_e(p, -40);
        load_seed({8'h3C, 8'(u)});
        draw(r, lat); chk("R2 sole low", r, p);
      end
    end

    // R3 exact rule on ties; R4 shifted copies
    tie_sweep(8'hFF, 60, -10, "R3 ties FF");
    tie_sweep(8'h81, 60, -10, "R3 ties 81");
    tie_sweep(8'h3C, -50, -128, "R4 ties 3C low");
    tie_sweep(8'h3C, 100, 30, "R4 ties 3C high");
    tie_sweep(8'h55, 127, -128, "R3 ties 55");

    // R5: exponential shares of a pair
    foreach (seen[k]) seen[k] = 0;
    for (int d = 4; d <= 16; d += 4) begin
      fill(-100); set_e(0, 40); set_e(1, 40 - d);
      c = 0;
      for (int u = 0; u < (1 << UW); u++) begin
        load_seed({8'h55, 8'(u)});
        draw(r, lat);
        if (r == 1) c++;
      end
      w = WMAX * $exp(-real'(d) / real'(1 << FRAC));
      e = (1 << UW) * w / (WMAX + w);
      lo = int'(e) - 3; hi = int'(e) + 3;
      chk("R5 share in window", int'(c >= lo && c <= hi), 1);
    end

    // R8: start/energy changes while busy are ignored
    fill(20);
    load_seed(16'h1200);
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    fill(-100); set_e(7, 100);
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    c = 0;
    for (int t = 0; t < 4*K + 20; t++) begin
      @(posedge clk); #1;
      if (done) begin c++; r = int'(idx); end
    end
    chk("R8 single completion", c, 1);
    chk("R8 captured energies", r, 0);
    chk("R7 index held", int'(idx), 0);

    // R9: zero seed and stepping
    fill(20);
    load_seed(16'h0000);
    moved = 0;
    for (int t = 0; t < 8; t++) begin
      draw(r, lat);
      if (r != 0) moved = 1;
    end
    chk("R9 zero seed steps", int'(moved), 1);
    load_seed(16'hACE1);
    foreach (seen[k]) seen[k] = 0;
    for (int t = 0; t < 32; t++) begin draw(r, lat); seen[r]++; end
    c = 0;
    foreach (seen[k]) if (seen[k] > 0) c++;
    chk("R9 draws vary", int'(c >= 3), 1);

    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule